// File: doc/BRIEF.md
# Configurable Output Macrocell for a Programmable Logic Array

This block is one output cell of a programmable logic device. Product terms come in from the AND plane. The cell ORs them into one sum. A polarity bit can invert that sum. The result then goes to the pin either straight through or through a D flip-flop. The cell also drives a tristate enable for the pin and returns a feedback signal to the AND plane.

All configuration inputs are static, and they drive four selectors:

| Selector | Job |
|---|---|
| Term gating | Decides whether the first product term joins the sum. |
| Output path | Picks the registered or the combinational value for the pin. |
| Enable source | Picks where the pin's tristate enable comes from. |
| Feedback source | Picks what is returned to the AND plane. |

The cell has two datapath modes, set by `cfg_registered`:

- **Combinational (`cfg_registered` = 0):** the pin carries the polarity-adjusted sum. The feedback carries the pin value.
- **Registered (`cfg_registered` = 1):** the pin carries the inverted flip-flop output. The feedback carries the flip-flop state.

The flip-flop captures the polarity-adjusted sum on every rising clock edge. It does this in both modes, so switching modes never stalls it.

Top module: `pld_macrocell`

## Requirements
- R1: The raw sum is the OR of product terms 1 to NUM_PT-1, plus term 0 unless the enable source is the term source. The enable source is the term source when `cfg_oe_sel` = 2'b11.
- R2: When `cfg_invert` = 0 the polarity-adjusted sum equals the raw sum. When `cfg_invert` = 1 it is the complement of the raw sum.
- R3: In combinational mode (`cfg_registered` = 0), `pin_out` equals the polarity-adjusted sum in the same cycle, and `fb_out` equals `pin_out`.
- R4: On each rising clock edge with `rst` low, the flip-flop stores the polarity-adjusted sum. In registered mode (`cfg_registered` = 1), after that edge `fb_out` equals the stored value and `pin_out` is its complement.
- R5: A rising edge with `rst` high clears the flip-flop. In registered mode this gives `fb_out` = 0 and `pin_out` = 1.
- R6: `pin_oe` depends on `cfg_oe_sel` as follows:

| `cfg_oe_sel` | `pin_oe` |
|---|---|
| 2'b00 | 1 |
| 2'b01 | 0 |
| 2'b10 | `oe_pin` |
| 2'b11 | `pt_in[0]` |

- R7: With `cfg_oe_sel` = 2'b11, a change on `pt_in[0]` alone has no effect on `pin_out` in combinational mode. It changes only `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flip-flop samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high, clears the flip-flop |
| pt_in | input | NUM_PT | Product terms from the AND plane |
| oe_pin | input | 1 | Global output-enable input |
| cfg_invert | input | 1 | Polarity bit: 1 inverts the sum |
| cfg_registered | input | 1 | Datapath mode: 1 registered, 0 combinational |
| cfg_oe_sel | input | 2 | Enable source select (see R6) |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Tristate enable for the pin |
| fb_out | output | 1 | Feedback into the AND plane |

## Verification
The assertions assume three things about the inputs:

- They are known values (no X).
- They settle between clock edges.
- Reset is held across at least one rising edge before any registered-mode result is expected.

The stimulus respects these assumptions. Every input change happens on the falling edge, and the run opens with a reset pulse. Every 2-bit enable code has a defined meaning, so the sweep covers all sixteen combinations of polarity, mode and enable source with no illegal values.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    // Source of the pin tristate enable
    typedef enum logic [1:0] {
        OE_ON   = 2'b00,
        OE_OFF  = 2'b01,
        OE_EXT  = 2'b10,
        OE_TERM = 2'b11
    } oe_src_e;

    // Datapath mode of the cell
    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } path_e;

endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pt_in,
    input  logic              term_steal,
    input  logic              invert,
    output logic              sum_raw,
    output logic              sum_pol
);
    logic [NUM_PT-1:0] gated;

    // Term 0 is removed from the OR when it serves as the enable source
    for (genvar i = 0; i < NUM_PT; i++) begin : g_gate
        if (i == 0) begin : g_first
            assign gated[i] = pt_in[i] & ~term_steal;
        end else begin : g_rest
            assign gated[i] = pt_in[i];
        end
    end

    assign sum_raw = |gated;
    assign sum_pol = sum_raw ^ invert;
endmodule

// File: rtl/mc_reg.sv
module mc_reg (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/mc_route.sv
module mc_route
    import pld_mc_pkg::*;
(
    input  path_e   path,
    input  oe_src_e oe_src,
    input  logic    oe_pin,
    input  logic    term0,
    input  logic    sum_pol,
    input  logic    q,
    output logic    pin_out,
    output logic    pin_oe,
    output logic    fb_out
);
    // Output and feedback selectors
    always_comb begin
        unique case (path)
            PATH_REG: begin
                pin_out = ~q;
                fb_out  = q;
            end
            PATH_COMB: begin
                pin_out = sum_pol;
                fb_out  = sum_pol;
            end
        endcase
    end

    // Enable selector
    always_comb begin
        unique case (oe_src)
            OE_ON:   pin_oe = 1'b1;
            OE_OFF:  pin_oe = 1'b0;
            OE_EXT:  pin_oe = oe_pin;
            OE_TERM: pin_oe = term0;
        endcase
    end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NUM_PT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PT-1:0] pt_in,
    input  logic              oe_pin,
    input  logic              cfg_invert,
    input  logic              cfg_registered,
    input  logic [1:0]        cfg_oe_sel,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);
    oe_src_e oe_src;
    path_e   path;
    logic    sum_raw;
    logic    sum_pol;
    logic    q;

    assign oe_src = oe_src_e'(cfg_oe_sel);
    assign path   = path_e'(cfg_registered);

    mc_sum #(.NUM_PT(NUM_PT)) u_sum (
        .pt_in      (pt_in),
        .term_steal (oe_src == OE_TERM),
        .invert     (cfg_invert),
        .sum_raw    (sum_raw),
        .sum_pol    (sum_pol)
    );

    mc_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (sum_pol),
        .q   (q)
    );

    mc_route u_route (
        .path    (path),
        .oe_src  (oe_src),
        .oe_pin  (oe_pin),
        .term0   (pt_in[0]),
        .sum_pol (sum_pol),
        .q       (q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb_out  (fb_out)
    );
endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk #(
    parameter int NUM_PT = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_PT-1:0] pt_in,
    input logic              oe_pin,
    input logic              cfg_invert,
    input logic              cfg_registered,
    input logic [1:0]        cfg_oe_sel,
    input logic              pin_out,
    input logic              pin_oe,
    input logic              fb_out,
    input logic              sum_raw,
    input logic              sum_pol
);
    logic past_rst_q;

    // R5: after a reset edge the registered path reads cleared
    always_ff @(posedge clk) begin
        if (past_rst_q && cfg_registered) begin
            p_reset_clear_r5: assert (fb_out == 1'b0 && pin_out == 1'b1);
        end
        past_rst_q <= rst;
    end

    p_term0_masked_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel == 2'b11 && pt_in[NUM_PT-1:1] == '0) |-> !sum_raw);

    p_comb_polarity_r2: assert property (@(posedge clk) disable iff (rst)
        !cfg_registered |-> (pin_out == (sum_raw ^ cfg_invert)));

    p_comb_feedback_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_registered |-> (fb_out == pin_out));

    p_reg_capture_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_registered |=> (!cfg_registered || fb_out == $past(sum_pol)));

    p_reg_complement_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_registered |-> (pin_out != fb_out));

    p_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel == 2'b01) |-> !pin_oe);

    p_oe_on_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel == 2'b00) |-> pin_oe);

    p_oe_ext_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel == 2'b10) |-> (pin_oe == oe_pin));

    p_oe_term_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_oe_sel == 2'b11) |-> (pin_oe == pt_in[0]));
endmodule

bind pld_macrocell pld_macrocell_chk #(.NUM_PT(NUM_PT)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pt_in          (pt_in),
    .oe_pin         (oe_pin),
    .cfg_invert     (cfg_invert),
    .cfg_registered (cfg_registered),
    .cfg_oe_sel     (cfg_oe_sel),
    .pin_out        (pin_out),
    .pin_oe         (pin_oe),
    .fb_out         (fb_out),
    .sum_raw        (sum_raw),
    .sum_pol        (sum_pol)
);

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;
    localparam int NUM_PT = 8;
    localparam int NPAT   = 8;
    // Product-term stimulus patterns
    localparam logic [NUM_PT-1:0] PT_PAT [NPAT] = '{
        8'h00, 8'h01, 8'h02, 8'h80, 8'h81, 8'h40, 8'hFF, 8'h10
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [NUM_PT-1:0] pt_in;
    logic              oe_pin;
    logic              cfg_invert;
    logic              cfg_registered;
    logic [1:0]        cfg_oe_sel;
    logic              pin_out, pin_oe, fb_out;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;
    logic exp_q;

    always #4 clk = ~clk;

    pld_macrocell #(.NUM_PT(NUM_PT)) u0 (
        .clk(clk), .rst(rst), .pt_in(pt_in), .oe_pin(oe_pin),
        .cfg_invert(cfg_invert), .cfg_registered(cfg_registered),
        .cfg_oe_sel(cfg_oe_sel), .pin_out(pin_out), .pin_oe(pin_oe),
        .fb_out(fb_out)
    );

    // Reference expressions built from the requirements
    function automatic logic ref_sum(input logic [NUM_PT-1:0] pt,
                                     input logic [1:0] sel, input logic inv);
        logic [NUM_PT-1:0] g;
        g = pt;
        if (sel == 2'b11) g[0] = 1'b0;
        return (|g) ^ inv;
    endfunction

    function automatic logic ref_oe(input logic [1:0] sel, input logic ext,
                                    input logic t0);
        case (sel)
            2'b00:   return 1'b1;
            2'b01:   return 1'b0;
            2'b10:   return ext;
            default: return t0;
        endcase
    endfunction

    // Compares {pin_out, pin_oe, fb_out}
    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] got;
        got = {pin_out, pin_oe, fb_out};
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pt_in = 8'hFF; oe_pin = 1'b0;
        cfg_invert = 1'b0; cfg_registered = 1'b1; cfg_oe_sel = 2'b00;
        @(posedge clk); #1;
        chk("R5 reset state", 3'b110);
        @(posedge clk); #1;

        // R4 capture then R5 mid-run clear
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R4 capture one", 3'b011);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R5 clear after run", 3'b110);

        // R7: term 0 as enable no longer reaches the sum
        @(negedge clk); rst = 1'b0; cfg_registered = 1'b0;
        cfg_oe_sel = 2'b11; pt_in = 8'h01; #1;
        chk("R7 term0 stolen", 3'b010);
        pt_in = 8'h00; #1;
        chk("R7 term0 low", 3'b000);
        cfg_invert = 1'b1; pt_in = 8'h01; #1;
        chk("R7 inverted", 3'b111);

        // Put the flop in a known state before the sweep
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        exp_q = 1'b0;
        @(negedge clk); rst = 1'b0;

        // Sweep: every configuration against every pattern
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int p = 0; p < NPAT; p++) begin
                logic s, oe;
                @(negedge clk);
                cfg_invert     = cfg[0];
                cfg_registered = cfg[1];
                cfg_oe_sel     = cfg[3:2];
                pt_in          = PT_PAT[p];
                oe_pin         = p[0];
                #1;
                s  = ref_sum(pt_in, cfg_oe_sel, cfg_invert);
                oe = ref_oe(cfg_oe_sel, oe_pin, pt_in[0]);
                if (cfg_registered)
                    chk("R4 R6 reg hold", {~exp_q, oe, exp_q});
                else
                    chk("R1 R2 R3 R6 comb", {s, oe, s});
                @(posedge clk);
                exp_q = s;
                #1;
                if (cfg_registered)
                    chk("R4 R1 R2 reg capture", {~exp_q, oe, exp_q});
                else
                    chk("R3 comb after edge", {s, oe, s});
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule